// File: doc/BRIEF.md
# Banked GPIO Controller with Password-Gated Pin Ownership

This block is a memory-mapped general purpose I/O controller for 256 pins, split into eight banks of 32. Software reaches it through a single-cycle word port: a write is taken on the clock edge where `bus_we` is high, and a read returns combinationally on `bus_rdata` for whatever `bus_addr` presents. Outputs are never written directly. They move through write-one-to-set and write-one-to-clear registers, so two agents can drive different bits of a bank without a read-modify-write race.

Every pin owns a configuration word holding its direction, the edge kind that raises an interrupt, and a debounce code that is stored for software and not used by the logic. A per-pin ownership bit guards that word. While the bit is 1 the pin is released and its configuration cannot change. The ownership registers can only be rewritten by the write that comes directly after a magic key is written to the key register. Input pins pass through a two-stage synchronizer. Matching edges latch into per-bank interrupt status bits that are cleared by writing 1. A single interrupt line reports any status bit whose mask is open.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, all outputs are 0, every pin's configuration reads 0x001 (input, no edge), every ownership bit and every mask bit is 1, all interrupt status bits are 0 and `irq` is low.
- R2: Pin p sits in bank p>>5 at bit p&31. Bank b's registers are at base+4*b with bases 0x000 output level, 0x020 input level, 0x040 set, 0x060 clear, 0x080 interrupt status, 0x0A0 mask-set, 0x0C0 mask-clear and 0x500 ownership. Pin p's configuration word is at 0x100+4*p.
- R3: Writing to 0x040+4*b raises the output bits written as 1. Bits written as 0 keep their value. The result reads back at 0x000+4*b and appears on `pin_out`.
- R4: Writing to 0x060+4*b lowers the output bits written as 1. Bits written as 0 keep their value.
- R5: In a configuration word, bit 0 is the direction (1 input, 0 output, driven on `pin_dir_in`), bits 4:3 are the edge kind, and bits 8:5 are the debounce code. Bits 2:1 and 31:9 read as 0.
- R6: A configuration write to a pin whose ownership bit is 1 is ignored. When that bit is 0, the write is stored.
- R7: A write to an ownership register is stored only if the immediately preceding write put 0x00A5A501 into the key register at 0x520. A 0 bit grants the pin and a 1 bit releases it.
- R8: Any other intervening write, a wrong key value, or a completed ownership write withdraws the permission. One key write permits at most one ownership write.
- R9: `pin_in` passes through a two-flop synchronizer. The synchronized level reads at 0x020+4*b two clock edges after the input changes.
- R10: For an input pin, edge kind 1 sets its status bit on a rising edge, 2 on a falling edge, 3 on either, and 0 never. Output pins never set status. Writing 1 to 0x080+4*b clears a bit, and a new edge in the same cycle wins over the clear.
- R11: Writing 1s to 0x0A0+4*b masks those bits and writing 1s to 0x0C0+4*b unmasks them. Both addresses read the mask. `irq` is high when any status bit is set with its mask bit at 0.
- R12: Reads of unmapped or misaligned addresses return 0. Writes to them, and to the output-level and input-level registers, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 11 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 256 | Pad input levels, asynchronous |
| pin_out | output | 256 | Output levels |
| pin_dir_in | output | 256 | Per-pin direction, 1 = input |
| irq | output | 1 | OR of unmasked interrupt status bits |

## Verification
Edge capture is tried with one pin cycled through all four edge kinds, each followed by a rise and a fall. This separates rising-only, falling-only, both and none, and a pin set as output with edges enabled shows that direction gates capture. The ownership path is driven with no key, with the key followed by an unrelated write, with a wrong key, and with two ownership writes after one key, so each way of losing permission is told apart from a real grant. Set and clear writes with mixed one and zero bits, plus writes of all zeros, separate per-bit updates from whole-word overwrites.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NBANK      = 8;
    localparam int BANK_W     = 32;
    localparam int NPIN       = NBANK * BANK_W;
    localparam int PIN_IDX_W  = $clog2(NPIN);
    localparam int BANK_IDX_W = $clog2(NBANK);
    localparam int ADDR_W     = 11;
    localparam int DATA_W     = 32;
    localparam int CFG_W      = 9;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h00A5_A501;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 11'h100;
    localparam logic [ADDR_W-1:0] OFS_OWN    = 11'h500;
    localparam logic [ADDR_W-1:0] OFS_KEY    = 11'h520;
    localparam int CFG_FIRST_WORD = int'(OFS_CFG) / 4;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    // bit order matches the configuration word: [8:5] [4:3] [2:1] [0]
    typedef struct packed {
        logic [3:0] debounce;
        edge_sel_e  edge_sel;
        logic [1:0] rsvd;
        logic       dir_in;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RST = '{debounce: 4'd0, edge_sel: EDGE_NONE,
                                     rsvd: 2'd0, dir_in: 1'b1};

    typedef enum logic [2:0] {
        GRP_OUT  = 3'd0,
        GRP_IN   = 3'd1,
        GRP_SET  = 3'd2,
        GRP_CLR  = 3'd3,
        GRP_IST  = 3'd4,
        GRP_MSET = 3'd5,
        GRP_MCLR = 3'd6,
        GRP_NONE = 3'd7
    } bank_grp_e;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge
    import gpio_pkg::*;
#(
    parameter int WIDTH = NPIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
        logic [WIDTH-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = din;
        st_d.stage2 = st_q.stage1;
        st_d.prev   = st_q.stage2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.stage2;
    assign rise  = st_q.stage2 & ~st_q.prev;
    assign fall  = ~st_q.stage2 & st_q.prev;
endmodule

// File: rtl/gpio_cfg_array.sv
module gpio_cfg_array
    import gpio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PIN_IDX_W-1:0] idx,
    input  logic [CFG_W-1:0]     wr_data,
    input  logic [NPIN-1:0]      owned_n,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NPIN-1:0]      dir_in,
    output logic [NPIN-1:0]      rise_en,
    output logic [NPIN-1:0]      fall_en
);
    pin_cfg_t [NPIN-1:0] cfg_d, cfg_q;
    pin_cfg_t            wr_cfg;

    always_comb begin
        wr_cfg      = pin_cfg_t'(wr_data);
        wr_cfg.rsvd = 2'd0;
        cfg_d       = cfg_q;
        if (wr_en && !owned_n[idx]) begin
            cfg_d[idx] = wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPIN; i++) cfg_q[i] <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_data = {{(DATA_W-CFG_W){1'b0}}, cfg_q[idx]};

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        assign dir_in[p]  = cfg_q[p].dir_in;
        // edge code bit 0 selects rising, bit 1 selects falling
        assign rise_en[p] = cfg_q[p].dir_in & cfg_q[p].edge_sel[0];
        assign fall_en[p] = cfg_q[p].dir_in & cfg_q[p].edge_sel[1];
    end
endmodule

// File: rtl/gpio_own_guard.sv
module gpio_own_guard
    import gpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  hit_key,
    input  logic                  hit_own,
    input  logic [BANK_IDX_W-1:0] bank,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  armed,
    output logic [NPIN-1:0]       owned_n
);
    typedef struct packed {
        logic                              armed;
        logic [NBANK-1:0][BANK_W-1:0]      own_n;
    } guard_st_t;

    guard_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            // every write decides the permission for the next one
            st_d.armed = hit_key && (wr_data == UNLOCK_KEY);
            if (hit_own && st_q.armed) begin
                st_d.own_n[bank] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b0;
            st_q.own_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed   = st_q.armed;
    assign owned_n = st_q.own_n;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic [gpio_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [gpio_pkg::DATA_W-1:0]  bus_wdata,
    output logic [gpio_pkg::DATA_W-1:0]  bus_rdata,
    input  logic [gpio_pkg::NPIN-1:0]    pin_in,
    output logic [gpio_pkg::NPIN-1:0]    pin_out,
    output logic [gpio_pkg::NPIN-1:0]    pin_dir_in,
    output logic                         irq
);
    typedef struct packed {
        logic [NBANK-1:0][BANK_W-1:0] outv;
        logic [NBANK-1:0][BANK_W-1:0] ist;
        logic [NBANK-1:0][BANK_W-1:0] imask;
    } core_st_t;

    core_st_t st_d, st_q;

    // address decode
    logic                  aligned, hit_bank, hit_cfg, hit_own, hit_key;
    bank_grp_e             grp;
    logic [BANK_IDX_W-1:0] bsel;
    logic [PIN_IDX_W-1:0]  cfg_idx;

    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        hit_bank = aligned && (bus_addr < OFS_CFG);
        hit_cfg  = aligned && (bus_addr >= OFS_CFG) && (bus_addr < OFS_OWN);
        hit_own  = aligned && (bus_addr[ADDR_W-1:5] == OFS_OWN[ADDR_W-1:5]);
        hit_key  = (bus_addr == OFS_KEY);
        grp      = bank_grp_e'(bus_addr[7:5]);
        bsel     = bus_addr[4:2];
        cfg_idx  = bus_addr[9:2] - PIN_IDX_W'(CFG_FIRST_WORD);
    end

    // submodules
    logic [NPIN-1:0]   sync_level, sync_rise, sync_fall;
    logic [NPIN-1:0]   rise_en, fall_en, owned_n;
    logic [DATA_W-1:0] cfg_rd;
    logic              own_armed;

    gpio_sync_edge #(.WIDTH(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .level (sync_level),
        .rise  (sync_rise),
        .fall  (sync_fall)
    );

    gpio_cfg_array u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && hit_cfg),
        .idx     (cfg_idx),
        .wr_data (bus_wdata[CFG_W-1:0]),
        .owned_n (owned_n),
        .rd_data (cfg_rd),
        .dir_in  (pin_dir_in),
        .rise_en (rise_en),
        .fall_en (fall_en)
    );

    gpio_own_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .hit_key (hit_key),
        .hit_own (hit_own),
        .bank    (bsel),
        .wr_data (bus_wdata),
        .armed   (own_armed),
        .owned_n (owned_n)
    );

    // next state
    logic [NPIN-1:0] edge_hit;

    always_comb begin
        edge_hit = (sync_rise & rise_en) | (sync_fall & fall_en);
        st_d     = st_q;
        if (bus_we && hit_bank) begin
            unique case (grp)
                GRP_SET:  st_d.outv[bsel]  = st_q.outv[bsel] | bus_wdata;
                GRP_CLR:  st_d.outv[bsel]  = st_q.outv[bsel] & ~bus_wdata;
                GRP_IST:  st_d.ist[bsel]   = st_q.ist[bsel] & ~bus_wdata;
                GRP_MSET: st_d.imask[bsel] = st_q.imask[bsel] | bus_wdata;
                GRP_MCLR: st_d.imask[bsel] = st_q.imask[bsel] & ~bus_wdata;
                default:  ;
            endcase
        end
        // a fresh edge takes precedence over a same-cycle clear
        st_d.ist = st_d.ist | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.outv  <= '0;
            st_q.ist   <= '0;
            st_q.imask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (hit_bank) begin
            unique case (grp)
                GRP_OUT:            bus_rdata = st_q.outv[bsel];
                GRP_IN:             bus_rdata = sync_level[bsel*BANK_W +: BANK_W];
                GRP_IST:            bus_rdata = st_q.ist[bsel];
                GRP_MSET, GRP_MCLR: bus_rdata = st_q.imask[bsel];
                default:            bus_rdata = '0;
            endcase
        end else if (hit_cfg) begin
            bus_rdata = cfg_rd;
        end else if (hit_own) begin
            bus_rdata = owned_n[bsel*BANK_W +: BANK_W];
        end
    end

    logic [NPIN-1:0] ist_flat;
    assign ist_flat = st_q.ist;
    assign pin_out  = st_q.outv;
    assign irq      = |(st_q.ist & ~st_q.imask);
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_dir_in,
    input logic              irq,
    input logic              armed,
    input logic [NPIN-1:0]   owned_n,
    input logic [NPIN-1:0]   ist
);
    // R7: ownership bits only move while permission is held
    a_r7_own_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(owned_n));

    // R7: permission only follows a correct key write
    a_r7_arm_from_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> ($past(bus_we) && $past(bus_addr) == OFS_KEY
                          && $past(bus_wdata) == UNLOCK_KEY));

    // R8: any write other than the key consumes the permission
    a_r8_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_we && bus_addr != OFS_KEY) |=> !armed);

    // R3: outputs never move without a bus write
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_out));

    // R6: direction never moves without a bus write
    a_r6_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_dir_in));

    // R10: status bits only clear through a bus write
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((ist & $past(ist)) == $past(ist)));

    // R11: the interrupt line needs a pending status bit
    a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ist != '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pin_out    (pin_out),
    .pin_dir_in (pin_dir_in),
    .irq        (irq),
    .armed      (own_armed),
    .owned_n    (owned_n),
    .ist        (ist_flat)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 50000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [10:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] pin_in = '0;
    logic [255:0] pin_out;
    logic [255:0] pin_dir_in;
    logic         irq;

    int checks = 0;
    int failures = 0;
    logic probe = 1'b0;
    bit done = 1'b0;

    // scoreboard queues: kind 0 bus read, 1 pin_out bank, 2 pin_dir_in bank, 3 irq
    int          kind_q[$];
    int          sel_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_dir_in (pin_dir_in),
        .irq        (irq)
    );

    // monitor: pops one expected item per probe and compares
    always @(negedge clk) begin
        if (probe && kind_q.size() > 0) begin
            int k; int s; logic [31:0] e; string t; logic [31:0] got;
            k = kind_q.pop_front(); s = sel_q.pop_front();
            e = exp_q.pop_front();  t = tag_q.pop_front();
            case (k)
                0:       got = bus_rdata;
                1:       got = pin_out[s*32 +: 32];
                2:       got = pin_dir_in[s*32 +: 32];
                default: got = {31'd0, irq};
            endcase
            checks++;
            if (got !== e) begin
                failures++;
                $display("FAIL %s: got %h expected %h", t, got, e);
            end
        end
    end

    task automatic push_check(input int k, input int s, input logic [31:0] e,
                              input string t);
        @(posedge clk); #1;
        bus_we = 1'b0;
        if (k == 0) bus_addr = 11'(s);
        kind_q.push_back(k); sel_q.push_back(s);
        exp_q.push_back(e);  tag_q.push_back(t);
        probe = 1'b1;
        @(negedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string t);
        push_check(0, a, e, t);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = 11'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(32'h000, 32'h0, "R1 output level bank0");
        rd(32'h100, 32'h1, "R1 config pin0");
        rd(32'h50C, 32'hFFFF_FFFF, "R1 ownership bank3");
        rd(32'h0A0, 32'hFFFF_FFFF, "R1 mask bank0");
        rd(32'h080, 32'h0, "R1 status bank0");
        push_check(2, 0, 32'hFFFF_FFFF, "R1 direction bank0");
        push_check(3, 0, 32'h0, "R1 irq low");

        // R3/R4 set and clear on bank1 (R2 bank stride)
        wr(32'h044, 32'h0000_00F0);
        rd(32'h004, 32'h0000_00F0, "R3 set bank1");
        push_check(1, 1, 32'h0000_00F0, "R2 pin_out bank1 slice");
        push_check(1, 0, 32'h0, "R2 bank0 untouched");
        wr(32'h064, 32'h0000_0030);
        rd(32'h004, 32'h0000_00C0, "R4 clear bank1");
        wr(32'h044, 32'h0);
        rd(32'h004, 32'h0000_00C0, "R3 zero bits keep value");
        wr(32'h064, 32'h0);
        rd(32'h004, 32'h0000_00C0, "R4 zero bits keep value");

        // R12 read-only and unmapped
        wr(32'h004, 32'h0000_FFFF);
        rd(32'h004, 32'h0000_00C0, "R12 output level is read-only");
        rd(32'h0E0, 32'h0, "R12 unmapped gap reads zero");
        rd(32'h524, 32'h0, "R12 past key reads zero");
        rd(32'h101, 32'h0, "R12 misaligned reads zero");

        // R6 configuration of a released pin (pin 40 = bank1 bit8)
        wr(32'h1A0, 32'h0);
        rd(32'h1A0, 32'h1, "R6 released pin config ignored");

        // R7 ownership without key
        wr(32'h504, 32'h0);
        rd(32'h504, 32'hFFFF_FFFF, "R7 ownership write without key ignored");
        wr(32'h520, 32'h00A5_A501);
        wr(32'h504, 32'hFFFF_FEFF);
        rd(32'h504, 32'hFFFF_FEFF, "R7 keyed ownership write taken");

        // R5/R6 owned pin configuration, reserved bits read 0
        wr(32'h1A0, 32'h0000_FFF6);
        rd(32'h1A0, 32'h0000_01F0, "R5 config fields and reserved zero");
        push_check(2, 1, 32'hFFFF_FEFF, "R5 direction output on pin 40");

        // R8 ways to lose permission
        wr(32'h520, 32'h00A5_A501);
        wr(32'h044, 32'h0);
        wr(32'h504, 32'h0);
        rd(32'h504, 32'hFFFF_FEFF, "R8 intervening write cancels key");
        wr(32'h520, 32'h00A5_A500);
        wr(32'h504, 32'h0);
        rd(32'h504, 32'hFFFF_FEFF, "R8 wrong key value");
        wr(32'h520, 32'h00A5_A501);
        wr(32'h504, 32'hFFFF_FEFE);
        wr(32'h504, 32'h0);
        rd(32'h504, 32'hFFFF_FEFE, "R8 one key one ownership write");

        // R11 mask set/clear; pin 32 = bank1 bit0, rising edge
        wr(32'h180, 32'h9);
        wr(32'h0C4, 32'h1);
        rd(32'h0A4, 32'hFFFF_FFFE, "R11 mask-clear opens bit0");
        rd(32'h0C4, 32'hFFFF_FFFE, "R11 mask readable at clear address");

        // R9/R10 rising
        pin_in[32] = 1'b1;
        idle(4);
        rd(32'h024, 32'h1, "R9 synchronized input level");
        rd(32'h084, 32'h1, "R10 rising edge captured");
        push_check(3, 0, 32'h1, "R11 irq from unmasked status");
        wr(32'h084, 32'h1);
        rd(32'h084, 32'h0, "R10 write-one clears status");
        push_check(3, 0, 32'h0, "R11 irq drops after clear");
        pin_in[32] = 1'b0;
        idle(4);
        rd(32'h084, 32'h0, "R10 rising-only ignores fall");
        rd(32'h024, 32'h0, "R9 input level low");

        // R10 falling only
        wr(32'h180, 32'h11);
        pin_in[32] = 1'b1;
        idle(4);
        rd(32'h084, 32'h0, "R10 falling-only ignores rise");
        pin_in[32] = 1'b0;
        idle(4);
        rd(32'h084, 32'h1, "R10 falling edge captured");
        wr(32'h084, 32'h1);

        // R10 both edges
        wr(32'h180, 32'h19);
        pin_in[32] = 1'b1;
        idle(4);
        rd(32'h084, 32'h1, "R10 both: rise captured");
        wr(32'h084, 32'h1);
        pin_in[32] = 1'b0;
        idle(4);
        rd(32'h084, 32'h1, "R10 both: fall captured");

        // R11 masking hides pending status
        wr(32'h0A4, 32'h1);
        push_check(3, 0, 32'h0, "R11 masked status keeps irq low");
        rd(32'h084, 32'h1, "R11 status kept while masked");

        // R10 edge kind none
        wr(32'h180, 32'h1);
        wr(32'h084, 32'h1);
        pin_in[32] = 1'b1;
        idle(4);
        pin_in[32] = 1'b0;
        idle(4);
        rd(32'h084, 32'h0, "R10 edge kind none");

        // R10 output-direction pin 40 with falling edge configured
        pin_in[40] = 1'b1;
        idle(4);
        pin_in[40] = 1'b0;
        idle(4);
        rd(32'h084, 32'h0, "R10 output pin never captures");
        rd(32'h024, 32'h0, "R9 bank1 input level back to zero");

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (R1..): got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule